// File: doc/BRIEF.md
# Adaptive Break-Before-Make Gate Sequencer

This block turns a single PWM command into two gate-enable outputs for a synchronous buck half-bridge: `hs_gate` for the upper switch and `ls_gate` for the lower, synchronous switch. It never lets both switches conduct at once. The logic is non-inverting: PWM high selects the upper switch and PWM low selects the lower one. Dead time is adaptive. Before either switch turns on, the sequencer first turns the other one off after a fixed propagation delay. It then waits for a digitized comparator flag that confirms the other switch is really off, and only then counts a further turn-on delay. For the lower switch the flag is `node_low`, which means the switch node is below about 1 V. For the upper switch the flag is `ls_gate_low`, which means the lower gate is below about 1 V.

All delays are whole clock cycles, derived from picosecond parameters and rounded up. The upper turn-on can be lengthened at run time by `hs_extra` cycles. If the switch node never falls after the upper gate drops, a timeout forces the lower switch on. It then holds it on until the next PWM edge. A synchronous-switch enable input keeps the lower gate off for light-load operation.

The sequencer is a ten-state machine:

| State | Gates on | What it does |
|---|---|---|
| `ST_OFF` | none | Reset state; waits for the first PWM edge |
| `ST_HS_TURNOFF` | upper | Holds the upper gate for the turn-off delay |
| `ST_WAIT_NODE` | none | Waits for `node_low` while the timeout counts |
| `ST_LS_DELAY` | none | Counts the lower turn-on delay |
| `ST_LS_ON` | lower | Lower switch on |
| `ST_LS_FORCED` | lower | Lower switch forced on by the timeout |
| `ST_LS_TURNOFF` | lower | Holds the lower gate for the turn-off delay |
| `ST_WAIT_GATE` | none | Waits for `ls_gate_low` |
| `ST_HS_DELAY` | none | Counts the base plus extra upper turn-on delay |
| `ST_HS_ON` | upper | Upper switch on |

Transitions when no PWM edge is seen:
- `ST_HS_TURNOFF` → `ST_WAIT_NODE` when its timer expires.
- `ST_WAIT_NODE` → `ST_LS_DELAY` when `node_low` is seen. This has priority over the timeout.
- `ST_WAIT_NODE` → `ST_LS_FORCED` when the timeout expires.
- `ST_LS_DELAY` → `ST_LS_ON` when its timer expires.
- `ST_LS_TURNOFF` → `ST_WAIT_GATE` when its timer expires.
- `ST_WAIT_GATE` → `ST_HS_DELAY` when `ls_gate_low` is seen.
- `ST_HS_DELAY` → `ST_HS_ON` when its timer expires.

A PWM edge overrides all of these transitions:
- A rising edge goes to `ST_HS_ON` if the upper gate is still high (a short low glitch). Otherwise it goes to `ST_LS_TURNOFF` if the lower gate is high, and to `ST_WAIT_GATE` if neither gate is high.
- A falling edge goes to `ST_LS_ON` if the lower gate is still high. Otherwise it goes to `ST_HS_TURNOFF` if the upper gate is high, and to `ST_WAIT_NODE` if neither gate is high.

Top module: `bbm_gate_seq`

## Requirements
- R1: With the default parameters, the design waits for the next clock edge and then counts one cycle of a 20 ns clock per 20 ns of delay. After reset both gates are low. They stay low until the first PWM edge, and a PWM input that is high at reset release counts as a rising edge.
- R2: After the clock edge that samples a falling PWM edge with the upper gate on, `hs_gate` stays high for the upper turn-off delay (1 cycle by default). It goes low at the following edge.
- R3: `ls_gate` rises only after `node_low` has been sampled high. It rises 1 + the lower turn-on delay (2 by default) = 3 edges after that sample.
- R4: If `node_low` is not seen within the timeout (20 cycles by default) after `hs_gate` falls, `ls_gate` is forced high. It stays high whatever `node_low` does, until the next PWM edge.
- R5: After the clock edge that samples a rising PWM edge with the lower gate on, `ls_gate` stays high for the lower turn-off delay (2 cycles by default). It then goes low.
- R6: `hs_gate` rises only after `ls_gate_low` has been sampled high. It rises 1 + the upper turn-on delay (2 by default) + `hs_extra` edges after that sample.
- R7: `hs_extra` is an unsigned count of cycles that adds directly to the upper turn-on delay.
- R8: While `sync_en` is low, `ls_gate` is low in every cycle. Raising `sync_en` while the sequencer is in a lower-on state raises `ls_gate` at once. A rising PWM edge seen while the lower gate is held low goes straight to waiting on `ls_gate_low`.
- R9: `hs_gate` and `ls_gate` are never high in the same cycle.
- R10: A PWM edge during a pending turn-on aborts it: the gate that was about to turn on never rises. The sequence restarts from the new edge, including a fresh switch-node timeout.
- R11: If PWM returns high while `hs_gate` is still high in its turn-off delay, `hs_gate` stays high with no gap.
- R12: The logic is non-inverting: PWM high leads to `hs_gate`, and PWM low leads to `ls_gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, high selects the upper switch |
| sync_en | input | 1 | Synchronous-switch enable, low keeps `ls_gate` low |
| node_low | input | 1 | Switch node below about 1 V |
| ls_gate_low | input | 1 | Lower gate voltage below about 1 V |
| hs_extra | input | EXTRA_W | Extra upper turn-on delay in cycles |
| hs_gate | output | 1 | Upper switch gate enable |
| ls_gate | output | 1 | Lower switch gate enable |

## Verification
The assertions check these properties on every cycle:
- the gates never overlap;
- `ls_gate` is low whenever `sync_en` is low;
- each gate changes only while PWM is at the level that allows it;
- the timer counts down by one each cycle;
- a forced lower-on state can be left only by a rising PWM edge.

Only the bench scenarios can show the exact delays from each PWM edge and feedback flag, the length of the timeout, how `hs_extra` adds to the delay, the abort and restart on an edge during a pending turn-on, and the glitch case where the upper gate never drops.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_HS_TURNOFF,
        ST_WAIT_NODE,
        ST_LS_DELAY,
        ST_LS_ON,
        ST_LS_FORCED,
        ST_LS_TURNOFF,
        ST_WAIT_GATE,
        ST_HS_DELAY,
        ST_HS_ON
    } seq_state_t;

    // Convert a delay in picoseconds into whole clock cycles, rounded up, at least one.
    function automatic int unsigned ps_to_cycles(input int unsigned dly_ps,
                                                 input int unsigned clk_ps);
        int unsigned cyc;
        cyc = (dly_ps + clk_ps - 1) / clk_ps;
        if (cyc == 0) cyc = 1;
        return cyc;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bbm_pwm_edge.sv
module bbm_pwm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    output logic rise,
    output logic fall
);
    logic pwm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm;
    end

    assign rise = pwm & ~pwm_q;
    assign fall = ~pwm & pwm_q;
endmodule

// File: rtl/bbm_timer.sv
module bbm_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - ONE;
    end

    assign expired = (cnt == '0);

    // R6: an armed timer falls by exactly one per cycle unless reloaded
    a_r6_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/bbm_gate_seq.sv
module bbm_gate_seq
    import bbm_pkg::*;
#(
    parameter int unsigned CLK_PS     = 20000,
    parameter int unsigned HS_OFF_PS  = 20000,
    parameter int unsigned LS_ON_PS   = 30000,
    parameter int unsigned LS_OFF_PS  = 30000,
    parameter int unsigned HS_ON_PS   = 30000,
    parameter int unsigned NODE_TO_PS = 400000,
    parameter int unsigned EXTRA_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwm_in,
    input  logic               sync_en,
    input  logic               node_low,
    input  logic               ls_gate_low,
    input  logic [EXTRA_W-1:0] hs_extra,
    output logic               hs_gate,
    output logic               ls_gate
);
    localparam int unsigned HS_OFF_CYC = ps_to_cycles(HS_OFF_PS, CLK_PS);
    localparam int unsigned LS_ON_CYC  = ps_to_cycles(LS_ON_PS, CLK_PS);
    localparam int unsigned LS_OFF_CYC = ps_to_cycles(LS_OFF_PS, CLK_PS);
    localparam int unsigned HS_ON_CYC  = ps_to_cycles(HS_ON_PS, CLK_PS);
    localparam int unsigned NODE_TO_CYC = ps_to_cycles(NODE_TO_PS, CLK_PS);
    localparam int unsigned HS_MAX_CYC = HS_ON_CYC + (2 ** EXTRA_W) - 1;
    localparam int unsigned MAX_CYC = max_u(max_u(max_u(HS_OFF_CYC, LS_ON_CYC),
                                                  max_u(LS_OFF_CYC, NODE_TO_CYC)),
                                            HS_MAX_CYC);
    localparam int unsigned TMR_W = $clog2(MAX_CYC + 1);

    seq_state_t       state_q, state_d;
    logic             pwm_rise, pwm_fall;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;

    bbm_pwm_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pwm   (pwm_in),
        .rise  (pwm_rise),
        .fall  (pwm_fall)
    );

    bbm_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state: a PWM edge overrides every pending step
    always_comb begin
        state_d = state_q;
        if (pwm_rise) begin
            if (hs_gate)      state_d = ST_HS_ON;
            else if (ls_gate) state_d = ST_LS_TURNOFF;
            else              state_d = ST_WAIT_GATE;
        end else if (pwm_fall) begin
            if (ls_gate)      state_d = ST_LS_ON;
            else if (hs_gate) state_d = ST_HS_TURNOFF;
            else              state_d = ST_WAIT_NODE;
        end else begin
            unique case (state_q)
                ST_OFF:        state_d = ST_OFF;
                ST_HS_TURNOFF: if (tmr_expired) state_d = ST_WAIT_NODE;
                ST_WAIT_NODE: begin
                    if (node_low)         state_d = ST_LS_DELAY;
                    else if (tmr_expired) state_d = ST_LS_FORCED;
                end
                ST_LS_DELAY:   if (tmr_expired) state_d = ST_LS_ON;
                ST_LS_ON:      state_d = ST_LS_ON;
                ST_LS_FORCED:  state_d = ST_LS_FORCED;
                ST_LS_TURNOFF: if (tmr_expired) state_d = ST_WAIT_GATE;
                ST_WAIT_GATE:  if (ls_gate_low) state_d = ST_HS_DELAY;
                ST_HS_DELAY:   if (tmr_expired) state_d = ST_HS_ON;
                ST_HS_ON:      state_d = ST_HS_ON;
                default:       state_d = ST_OFF;
            endcase
        end
    end

    // Timer reload on every state entry or edge
    always_comb begin
        tmr_load = (state_d != state_q) || pwm_rise || pwm_fall;
        unique case (state_d)
            ST_HS_TURNOFF: tmr_val = TMR_W'(HS_OFF_CYC - 1);
            ST_WAIT_NODE:  tmr_val = TMR_W'(NODE_TO_CYC - 1);
            ST_LS_DELAY:   tmr_val = TMR_W'(LS_ON_CYC - 1);
            ST_LS_TURNOFF: tmr_val = TMR_W'(LS_OFF_CYC - 1);
            ST_HS_DELAY:   tmr_val = TMR_W'(HS_ON_CYC - 1) + TMR_W'(hs_extra);
            default:       tmr_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        hs_gate = (state_q == ST_HS_TURNOFF) || (state_q == ST_HS_ON);
        ls_gate = sync_en && ((state_q == ST_LS_TURNOFF) || (state_q == ST_LS_ON) ||
                              (state_q == ST_LS_FORCED));
    end

    // R9: gates never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R8: disabled synchronous switch keeps its gate low
    a_r8_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> !ls_gate);

    // R6, R12: upper gate rises only while PWM is high
    a_r6_hs_rise_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(pwm_in));

    // R2: upper gate falls only after PWM went low
    a_r2_hs_fall_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_gate) |-> $past(!pwm_in));

    // R3, R12: lower gate rises (sync_en steady) only while PWM is low
    a_r3_ls_rise_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_gate) && sync_en && $past(sync_en)) |-> $past(!pwm_in));

    // R4: forced lower-on holds until a rising PWM edge
    a_r4_forced_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LS_FORCED && !pwm_rise) |=> (state_q == ST_LS_FORCED));
endmodule

// File: tb/bbm_gate_seq_test.sv
`timescale 1ns/1ps
module bbm_gate_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic       sync_en = 1'b1;
    logic       node_low = 1'b0;
    logic       ls_gate_low = 1'b1;
    logic [3:0] hs_extra = 4'd0;
    logic       hs_gate, ls_gate;

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bbm_gate_seq uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .sync_en(sync_en),
        .node_low(node_low), .ls_gate_low(ls_gate_low), .hs_extra(hs_extra),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    // Row: {pwm, node_low, ls_gate_low, sync_en, exp_hs, exp_ls}
    localparam logic [5:0] VEC [32] = '{
        6'b001100, 6'b101100, 6'b101100, 6'b101100, 6'b101110, 6'b101110,
        6'b001110, 6'b001100, 6'b011100, 6'b011100, 6'b011101, 6'b010101,
        6'b110101, 6'b110101, 6'b110100, 6'b110100, 6'b111100, 6'b111100,
        6'b111110, 6'b101110, 6'b001010, 6'b001000, 6'b011000, 6'b011000,
        6'b011000, 6'b011000, 6'b010101, 6'b010000, 6'b101000, 6'b101000,
        6'b101000, 6'b101010
    };

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic eh, input logic el, input string tag);
        checks++;
        if (hs_gate !== eh || ls_gate !== el) begin
            errors++;
            $display("FAIL %s: hs=%0b ls=%0b expected hs=%0b ls=%0b",
                     tag, hs_gate, ls_gate, eh, el);
        end
    endtask

    always @(negedge clk) if (rst_n && hs_gate && ls_gate) overlap++;

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: hs=%0b ls=%0b expected run to finish", hs_gate, ls_gate);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(2);
        chk(0, 0, "R1 in reset");
        rst_n = 1'b1;
        step(30);
        chk(0, 0, "R1 quiet until first edge");

        // Table of per-cycle vectors
        for (int i = 0; i < 32; i++) begin
            logic eh, el;
            {pwm_in, node_low, ls_gate_low, sync_en, eh, el} = VEC[i];
            step(1);
            chk(eh, el, $sformatf("table R2 R3 R5 R6 R8 R12 row %0d", i));
        end
        sync_en = 1'b1;

        // R4 timeout from upper-on
        pwm_in = 0; node_low = 0;
        step(1); chk(1, 0, "R2 hs held in turn-off");
        step(1); chk(0, 0, "R2 hs off");
        step(19); chk(0, 0, "R4 before timeout");
        step(1); chk(0, 1, "R4 forced on");
        node_low = 1; step(1); node_low = 0; step(4);
        chk(0, 1, "R4 forced held despite node flag");
        pwm_in = 1; ls_gate_low = 0;
        step(2); chk(0, 1, "R5 ls held in turn-off");
        step(1); chk(0, 0, "R5 ls off");
        ls_gate_low = 1;
        step(2); chk(0, 0, "R6 hs waits base delay");
        step(1); chk(1, 0, "R6 hs on");

        // R7 extra upper delay
        pwm_in = 0; node_low = 1;
        step(5); chk(0, 1, "R3 ls on after node flag");
        hs_extra = 4'd5; pwm_in = 1; ls_gate_low = 0;
        step(3); chk(0, 0, "R5 ls off before extra test");
        ls_gate_low = 1;
        step(7); chk(0, 0, "R7 extra delay pending");
        step(1); chk(1, 0, "R7 extra delay elapsed");
        hs_extra = 4'd0;

        // R10 abort a pending upper turn-on
        pwm_in = 0; node_low = 1;
        step(5); chk(0, 1, "R10 setup ls on");
        pwm_in = 1; ls_gate_low = 0;
        step(3); chk(0, 0, "R10 setup ls off");
        ls_gate_low = 1;
        step(1); chk(0, 0, "R10 upper turn-on pending");
        pwm_in = 0; node_low = 0;
        step(1); chk(0, 0, "R10 aborted, hs never rose");
        step(19); chk(0, 0, "R10 fresh timeout not yet");
        step(1); chk(0, 1, "R10 timeout restarted from new edge");

        // R11 short low glitch while upper is on
        pwm_in = 1;
        step(6); chk(1, 0, "R11 setup hs on");
        pwm_in = 0;
        step(1); chk(1, 0, "R11 hs in turn-off");
        pwm_in = 1;
        step(1); chk(1, 0, "R11 hs kept on");
        step(3); chk(1, 0, "R11 hs still on");

        // R1 reset mid-run, then PWM high at release acts as rising edge
        rst_n = 0; #1;
        chk(0, 0, "R1 async reset clears gates");
        step(2); rst_n = 1;
        step(1); chk(0, 0, "R1 high PWM at release waits gate");
        step(3); chk(1, 0, "R1 high PWM at release gives hs");

        checks++;
        if (overlap != 0) begin
            errors++;
            $display("FAIL R9 overlap: cycles=%0d expected 0", overlap);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule